// File: doc/BRIEF.md
# Auto-Negotiation Advertisement Register

This block holds the advertisement word that an Ethernet PHY offers to its link partner during auto-negotiation. It sits in the PHY's management register file at index 4. It also sends the four advertised speed/duplex abilities and a negotiation-enable flag to the negotiation engine.

The abilities come from one of two sources, chosen by a mode strap. In software mode they are a writable register that resets to "advertise everything". In hardware mode they are read-only. The speed and duplex straps then select exactly one ability, or none when negotiation is strapped off. All straps are captured while reset is held. The values latched at reset release stay in force until the next reset.

Three reserved bits in the word are protected from writes. A command-override bit, kept in another register of the file, must be set before these bits can be changed.

Top module: `an_adv_ctrl`

## Requirements
- R1: A read at index 4 returns bits 4:0 = 00001, bits 15:13 = 000, bits 12:10 = the reserved field and bits 8:5 = `adv_abil`. A read at any other index returns 0x0000.
- R2: In software mode (`sw_mode` = 1 at reset), the abilities come up as 1111 and the reserved field as 000. Read at index 4 after reset, the word is 0x01E1.
- R3: In software mode, a write at index 4 loads write-data bits 8:5 into the abilities on the next clock edge. A write at any other index leaves the word unchanged.
- R4: Bit 9 (the 100BASE-T4 ability) and bits 15:13 always read 0, and bits 4:0 always read 00001, whatever has been written.
- R5: Write-data bits 12:10 load the reserved field only when `ovr_en` = 1 during a write at index 4. Otherwise the reserved field keeps its value.
- R6: In hardware mode (`sw_mode` = 0 at reset), writes to bits 8:5 have no effect on `adv_abil` or on the read-back value.
- R7: In hardware mode with `an_strap` = 1, `adv_abil` is one-hot at bit {`speed_strap`,`duplex_strap`}, and `neg_en` = 1. Bit 3 (word bit 8) is 100 Mb/s full duplex, bit 2 is 100 half, bit 1 is 10 full and bit 0 is 10 half.
- R8: In hardware mode with `an_strap` = 0, `adv_abil` = 0000 and `neg_en` = 0.
- R9: The straps are latched on every clock edge that has `rst` high. Strap changes after reset release have no effect until the next reset.
- R10: While `rst` is high, `adv_abil` = 0 and `neg_en` = 0. From the first clock edge after release, both take their strapped or programmed values. In software mode `neg_en` follows `an_strap`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Register index for read and write |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| sw_mode | input | 1 | Mode strap: 1 software, 0 hardware |
| an_strap | input | 1 | Auto-negotiation enable strap |
| speed_strap | input | 1 | Speed strap: 1 selects 100 Mb/s |
| duplex_strap | input | 1 | Duplex strap: 1 selects full duplex |
| ovr_en | input | 1 | Command-override bit from the extended control register |
| adv_abil | output | 4 | Advertised abilities (word bits 8:5) |
| neg_en | output | 1 | Negotiation enable to the engine |

## Verification
Read data is combinational in the address, so a read is due in the same cycle the address is presented. A write shows up after exactly one clock edge. The outputs leave their reset value after the first edge that sees `rst` low.

The driver changes inputs on the falling edge and queues the expected word at that moment. The monitor compares two nanoseconds later, inside the same low phase. Between a write and its read there is always at least one rising edge.

The strap checks reset with each speed/duplex pair in turn. They then move the pins after release to show that the latched values hold.

// File: rtl/an_adv_pkg.sv
package an_adv_pkg;

    localparam int DATA_W  = 16;
    localparam int ABIL_W  = 4;
    localparam int RSVD_W  = 3;
    localparam int SEL_W   = 5;
    localparam logic [SEL_W-1:0] SELECTOR_CODE = 5'b00001;

    // strap pins as latched at reset
    typedef struct packed {
        logic sw;   // 1: software mode
        logic an;   // negotiation enabled
        logic spd;  // 1: 100 Mb/s
        logic dpx;  // 1: full duplex
    } strap_t;

    // layout of the advertisement word
    typedef struct packed {
        logic [2:0]        top;   // 15:13 read zero
        logic [RSVD_W-1:0] rsvd;  // 12:10 override-protected
        logic              t4;    // 9 never supported
        logic [ABIL_W-1:0] abil;  // 8:5 abilities
        logic [SEL_W-1:0]  sel;   // 4:0 selector
    } adv_word_t;

    // one-hot ability chosen by speed and duplex straps
    function automatic logic [ABIL_W-1:0] pick_ability(input logic spd, input logic dpx);
        logic [ABIL_W-1:0] v;
        v = '0;
        v[{spd, dpx}] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/an_strap_latch.sv
module an_strap_latch
    import an_adv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  strap_t pins,
    output strap_t strap_q,
    output logic   run_q
);
    // pins follow while reset is held; frozen after release
    always_ff @(posedge clk) begin
        if (rst) begin
            strap_q <= pins;
            run_q   <= 1'b0;
        end else begin
            run_q   <= 1'b1;
        end
    end
endmodule

// File: rtl/an_ability_field.sv
module an_ability_field
    import an_adv_pkg::*;
#(
    parameter int W = ABIL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  strap_t       strap,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] abil
);
    logic [W-1:0] soft_q;

    always_ff @(posedge clk) begin
        if (rst)
            soft_q <= '1;
        else if (wr_en && strap.sw)
            soft_q <= wdata;
    end

    always_comb begin
        if (!run)
            abil = '0;
        else if (strap.sw)
            abil = soft_q;
        else if (strap.an)
            abil = W'(pick_ability(strap.spd, strap.dpx));
        else
            abil = '0;
    end
endmodule

// File: rtl/an_rsvd_bits.sv
module an_rsvd_bits #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         ovr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en && ovr_en)
            q <= wdata;
    end
endmodule

// File: rtl/an_adv_ctrl.sv
module an_adv_ctrl
    import an_adv_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] REG_INDEX = ADDR_W'(4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              sw_mode,
    input  logic              an_strap,
    input  logic              speed_strap,
    input  logic              duplex_strap,
    input  logic              ovr_en,
    output logic [ABIL_W-1:0] adv_abil,
    output logic              neg_en
);
    strap_t            pins, strap_q;
    logic              run_q;
    logic              hit, wr_en;
    adv_word_t         wr_word, rd_word;
    logic [RSVD_W-1:0] rsvd_q;
    logic              unused_wbits;

    assign pins    = '{sw: sw_mode, an: an_strap, spd: speed_strap, dpx: duplex_strap};
    assign hit     = (reg_addr == REG_INDEX);
    assign wr_en   = reg_wr && hit;
    assign wr_word = reg_wdata;
    assign unused_wbits = ^{wr_word.top, wr_word.t4, wr_word.sel};

    an_strap_latch u_strap (
        .clk(clk), .rst(rst), .pins(pins), .strap_q(strap_q), .run_q(run_q)
    );

    an_ability_field #(.W(ABIL_W)) u_abil (
        .clk(clk), .rst(rst), .run(run_q), .strap(strap_q),
        .wr_en(wr_en), .wdata(wr_word.abil), .abil(adv_abil)
    );

    an_rsvd_bits #(.W(RSVD_W)) u_rsvd (
        .clk(clk), .rst(rst), .wr_en(wr_en), .ovr_en(ovr_en),
        .wdata(wr_word.rsvd), .q(rsvd_q)
    );

    assign neg_en = run_q && strap_q.an;

    always_comb begin
        rd_word      = '0;
        rd_word.sel  = SELECTOR_CODE;
        rd_word.t4   = 1'b0;
        rd_word.rsvd = rsvd_q;
        rd_word.abil = adv_abil;
    end

    assign reg_rdata = hit ? DATA_W'(rd_word) : '0;
endmodule

// File: rtl/an_adv_chk.sv
module an_adv_chk
    import an_adv_pkg::*;
#(
    parameter int                ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] REG_INDEX = ADDR_W'(4)
) (
    input logic              clk,
    input logic              rst,
    input logic              sw_mode,
    input logic              an_strap,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              ovr_en,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [ABIL_W-1:0] adv_abil,
    input logic              neg_en,
    input logic [RSVD_W-1:0] rsvd_q
);
    logic sw_c, an_c, live;

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_c <= sw_mode;
            an_c <= an_strap;
            live <= 1'b0;
        end else begin
            live <= 1'b1;
        end
    end

    a_r4_fixed_bits: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == REG_INDEX) |-> (reg_rdata[15:13] == 3'b000 && reg_rdata[9] == 1'b0
            && reg_rdata[4:0] == 5'b00001 && reg_rdata[12:10] == rsvd_q
            && reg_rdata[8:5] == adv_abil));

    a_r5_rsvd_locked: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == REG_INDEX && !ovr_en) |=> $stable(rsvd_q));

    a_r6_hw_read_only: assert property (@(posedge clk) disable iff (rst)
        (live && !sw_c) |=> $stable(adv_abil));

    a_r7_single_ability: assert property (@(posedge clk) disable iff (rst)
        (live && !sw_c && an_c) |-> ($countones(adv_abil) == 1 && neg_en));

    a_r8_no_negotiation: assert property (@(posedge clk) disable iff (rst)
        (live && !sw_c && !an_c) |-> (adv_abil == '0 && !neg_en));
endmodule

bind an_adv_ctrl an_adv_chk #(.ADDR_W(ADDR_W), .REG_INDEX(REG_INDEX)) u_chk (
    .clk(clk), .rst(rst), .sw_mode(sw_mode), .an_strap(an_strap),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .ovr_en(ovr_en),
    .reg_rdata(reg_rdata), .adv_abil(adv_abil), .neg_en(neg_en), .rsvd_q(rsvd_q)
);

// File: tb/sim_an_adv_ctrl.sv
`timescale 1ns/1ps
module sim_an_adv_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = 5'd4;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_rdata;
    logic        sw_mode = 1'b1, an_strap = 1'b1, speed_strap = 1'b0, duplex_strap = 1'b0;
    logic        ovr_en = 1'b0;
    logic [3:0]  adv_abil;
    logic        neg_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] q_rd[$];
    logic [3:0]  q_adv[$];
    logic        q_neg[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    an_adv_ctrl u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .sw_mode(sw_mode),
        .an_strap(an_strap), .speed_strap(speed_strap), .duplex_strap(duplex_strap),
        .ovr_en(ovr_en), .adv_abil(adv_abil), .neg_en(neg_en)
    );

    // monitor: compares queued expectations inside the low phase
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_rd.size() > 0) begin
                logic [15:0] e_rd;
                logic [3:0]  e_adv;
                logic        e_neg;
                string       t;
                e_rd = q_rd.pop_front();
                e_adv = q_adv.pop_front();
                e_neg = q_neg.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (reg_rdata !== e_rd || adv_abil !== e_adv || neg_en !== e_neg) begin
                    errors++;
                    $display("FAIL %s: rdata=%h adv=%b neg=%b expected rdata=%h adv=%b neg=%b",
                             t, reg_rdata, adv_abil, neg_en, e_rd, e_adv, e_neg);
                end
            end
        end
    end

    task automatic expect_at(input logic [4:0] a, input logic [15:0] rd,
                             input logic [3:0] adv, input logic neg, input string tag);
        @(negedge clk);
        reg_addr = a;
        q_rd.push_back(rd);
        q_adv.push_back(adv);
        q_neg.push_back(neg);
        q_tag.push_back(tag);
    endtask

    task automatic write_reg(input logic [4:0] a, input logic [15:0] d, input logic ovr);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        ovr_en = ovr;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        ovr_en = 1'b0;
    endtask

    task automatic do_reset(input logic sw, input logic an, input logic s, input logic d);
        @(negedge clk);
        rst = 1'b1;
        sw_mode = sw; an_strap = an; speed_strap = s; duplex_strap = d;
        repeat (3) @(negedge clk);
        // R10: quiet outputs while reset is held
        expect_at(5'd4, 16'h0001, 4'b0000, 1'b0, "R10 in reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [15:0] word(input logic [2:0] rs, input logic [3:0] ab);
        return {3'b000, rs, 1'b0, ab, 5'b00001};
    endfunction

    initial begin
        // software mode
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        expect_at(5'd4, 16'h01E1, 4'b1111, 1'b1, "R2 sw reset word / R10 release");
        expect_at(5'd3, 16'h0000, 4'b1111, 1'b1, "R1 other index reads zero");
        write_reg(5'd4, 16'hFFFF, 1'b0);
        expect_at(5'd4, word(3'b000, 4'b1111), 4'b1111, 1'b1, "R4 bit9/top/selector fixed, R5 locked");
        write_reg(5'd4, 16'h0000, 1'b0);
        expect_at(5'd4, word(3'b000, 4'b0000), 4'b0000, 1'b1, "R3 clear abilities");
        write_reg(5'd4, 16'h1CA0, 1'b1);
        expect_at(5'd4, 16'h1CA1, 4'b0101, 1'b1, "R5 override write, R3 load");
        write_reg(5'd5, 16'h0000, 1'b1);
        expect_at(5'd4, 16'h1CA1, 4'b0101, 1'b1, "R3 other index ignored");
        write_reg(5'd4, 16'h01E0, 1'b0);
        expect_at(5'd4, 16'h1DE1, 4'b1111, 1'b1, "R5 rsvd kept without override");
        expect_at(5'd9, 16'h0000, 4'b1111, 1'b1, "R1 other index reads zero");

        // software mode, negotiation strap off
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        expect_at(5'd4, 16'h01E1, 4'b1111, 1'b0, "R10 sw neg_en follows strap");

        // hardware mode, every strap pair
        for (int k = 0; k < 4; k++) begin
            logic [3:0] oh;
            oh = 4'b0001 << k;
            do_reset(1'b0, 1'b1, k[1], k[0]);
            expect_at(5'd4, word(3'b000, oh), oh, 1'b1, "R7 hw one-hot ability");
        end

        // hardware read-only and strap freeze
        do_reset(1'b0, 1'b1, 1'b1, 1'b0);
        write_reg(5'd4, 16'h01E0, 1'b0);
        expect_at(5'd4, word(3'b000, 4'b0100), 4'b0100, 1'b1, "R6 hw write ignored");
        write_reg(5'd4, 16'h0000, 1'b0);
        expect_at(5'd4, word(3'b000, 4'b0100), 4'b0100, 1'b1, "R6 hw clear ignored");
        @(negedge clk);
        speed_strap = 1'b0; duplex_strap = 1'b1; an_strap = 1'b0; sw_mode = 1'b1;
        repeat (2) @(negedge clk);
        expect_at(5'd4, word(3'b000, 4'b0100), 4'b0100, 1'b1, "R9 pins moved after release");

        // hardware, negotiation off
        do_reset(1'b0, 1'b0, 1'b1, 1'b1);
        expect_at(5'd4, 16'h0001, 4'b0000, 1'b0, "R8 hw negotiation off");
        write_reg(5'd4, 16'h1DE0, 1'b1);
        expect_at(5'd4, 16'h1C01, 4'b0000, 1'b0, "R8 abilities stay zero, R5 rsvd written");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule